// File: doc/BRIEF.md
# Symmetric Fold and Recurrence Operand Builder

This block prepares the operands that a six-element linear convolver needs when it evaluates a 26-point modified sine transform. A host weights each raw sample by its cosine term and then streams the 26 weighted samples in, one per accepted beat. The block keeps the first thirteen samples. As each of the last thirteen arrives, it meets its mirror partner, and the block folds the two into a signed sum and a signed difference. Once the frame is complete, the block runs a first-order, sign-alternating recurrence over each folded sequence. This gives two auxiliary sequences, lane a and lane b, each thirteen long.

It then emits twelve pair operands, six for lane a followed by six for lane b. Each operand adds two auxiliary elements whose indices sum to thirteen, and the operands come out in the slot order the convolver's tag schedule expects. The thirteenth element of each lane is latched on a side port for the post-processing stage. All arithmetic is exact two's complement. Internal widths carry enough guard bits that no input pattern can wrap.

The controller is a five-state machine:
- ST_IDLE waits for a start beat and moves to ST_LOAD_LO when sample 0 is taken.
- ST_LOAD_LO stores samples 1 to 12 and moves to ST_LOAD_HI after sample 12.
- ST_LOAD_HI folds samples 13 to 25 against their stored partners and moves to ST_RECUR after sample 25.
- ST_RECUR spends one cycle per recurrence step, thirteen in all, then moves to ST_EMIT.
- ST_EMIT spends one cycle per operand, twelve in all, then returns to ST_IDLE.

Top module: `mdst_fold_pre`

## Requirements
- R1: After reset, in_ready is 1 and pair_valid is 0.
- R2: In idle, a sample is taken only when in_valid and in_start are both 1, and that sample becomes sample 0. Samples 1 to 25 are taken on each later cycle with in_valid at 1, whatever in_start is. Cycles with in_valid at 0 are skipped. In idle, in_valid without in_start has no effect.
- R3: in_ready is 0 from the cycle after sample 25 is taken until emission starts. Start or valid beats during that time are ignored.
- R4: For i in 0..12, the lane a fold is u(i) = s(i) + s(25-i), negated when i is even.
- R5: For i in 0..12, the lane b fold is v(i) = s(i) - s(25-i).
- R6: Each lane's auxiliary sequence runs from index 1 to 13. Its first element is the lane's fold at index 0, used without any sign change. For i = 1..12, element i+1 equals the fold at i, negated when i is even, minus element i.
- R7: Each emitted operand is aux(p) + aux(13-p). For slots 0 to 5, p takes the values 1, 2, 4, 5, 3 and 6 in turn.
- R8: A frame produces twelve beats with pair_valid at 1 on consecutive cycles. pair_lane is 0 (lane a) for the first six and 1 (lane b) for the last six. pair_slot counts 0 to 5 within each lane.
- R9: tail_a and tail_b hold aux(13) of lanes a and b. They are valid from the frame's first emitted beat and do not change while its beats are emitted.
- R10: Full-scale inputs, including all samples at the most negative code and mirrored patterns of alternating sign, give exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample beat qualifier |
| in_start | input | 1 | Marks sample 0 of a frame |
| in_sample | input | SAMPLE_W | Weighted sample, signed |
| in_ready | output | 1 | Block is idle or loading a frame |
| pair_valid | output | 1 | An operand is presented |
| pair_lane | output | 1 | 0 for lane a, 1 for lane b |
| pair_slot | output | 3 | Slot index 0 to 5 within the lane |
| pair_data | output | SAMPLE_W+6 | Pair operand, signed |
| tail_a | output | SAMPLE_W+5 | Lane a aux(13), signed |
| tail_b | output | SAMPLE_W+5 | Lane b aux(13), signed |

## Verification
The properties assume the input side follows the frame handshake. A frame opens with one start beat in idle and then supplies exactly 25 further valid beats before any new start counts. With that assumption, emission is always one clean burst of twelve beats, in lane order and slot order, with steady tails. The stimulus keeps to this by holding in_start high only on sample 0 of each frame and by waiting for in_ready between frames. Deliberate start beats sent while the block is busy, and stray valid beats in idle, fall exactly in the windows where the rules say they must be ignored.

// File: rtl/mdst_fold_pkg.sv
package mdst_fold_pkg;

    localparam int FRAME_N  = 26;
    localparam int HALF_M   = FRAME_N / 2;
    localparam int PAIR_CNT = (HALF_M - 1) / 2;
    localparam int SLOT_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_LO,
        ST_LOAD_HI,
        ST_RECUR,
        ST_EMIT
    } fold_state_e;

    // lower index of the pair presented in a slot; partner is HALF_M minus it
    function automatic int pair_low(input int slot);
        case (slot)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 5;
            4:       return 3;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/mdst_fold_unit.sv
module mdst_fold_unit #(
    parameter int IN_W   = 16,
    parameter int FOLD_W = IN_W + 2
) (
    input  logic signed [IN_W-1:0]   early,
    input  logic signed [IN_W-1:0]   late,
    input  logic                     negate,
    output logic signed [FOLD_W-1:0] sum_fold,
    output logic signed [FOLD_W-1:0] dif_fold
);

    logic signed [FOLD_W-1:0] early_x;
    logic signed [FOLD_W-1:0] late_x;
    logic signed [FOLD_W-1:0] both;

    always_comb begin
        early_x  = {{(FOLD_W-IN_W){early[IN_W-1]}}, early};
        late_x   = {{(FOLD_W-IN_W){late[IN_W-1]}}, late};
        both     = early_x + late_x;
        sum_fold = negate ? -both : both;
        dif_fold = early_x - late_x;
    end

endmodule

// File: rtl/mdst_recur_unit.sv
module mdst_recur_unit #(
    parameter int FOLD_W = 18,
    parameter int AUX_W  = 21
) (
    input  logic                     first,
    input  logic                     flip,
    input  logic signed [FOLD_W-1:0] fold_in,
    input  logic signed [AUX_W-1:0]  prev,
    output logic signed [AUX_W-1:0]  next
);

    logic signed [AUX_W-1:0] ext;
    logic signed [AUX_W-1:0] term;

    always_comb begin
        ext  = {{(AUX_W-FOLD_W){fold_in[FOLD_W-1]}}, fold_in};
        term = flip ? -ext : ext;
        next = first ? ext : (term - prev);
    end

endmodule

// File: rtl/mdst_pair_adder.sv
module mdst_pair_adder #(
    parameter int AUX_W  = 21,
    parameter int PAIR_W = AUX_W + 1
) (
    input  logic signed [AUX_W-1:0]  op_lo,
    input  logic signed [AUX_W-1:0]  op_hi,
    output logic signed [PAIR_W-1:0] pair_sum
);

    always_comb begin
        pair_sum = {{(PAIR_W-AUX_W){op_lo[AUX_W-1]}}, op_lo}
                 + {{(PAIR_W-AUX_W){op_hi[AUX_W-1]}}, op_hi};
    end

endmodule

// File: rtl/mdst_fold_pre.sv
module mdst_fold_pre
    import mdst_fold_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    localparam int FOLD_W   = SAMPLE_W + 2,
    localparam int AUX_W    = SAMPLE_W + 1 + $clog2(HALF_M),
    localparam int PAIR_W   = AUX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_start,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       in_ready,
    output logic                       pair_valid,
    output logic                       pair_lane,
    output logic [SLOT_W-1:0]          pair_slot,
    output logic signed [PAIR_W-1:0]   pair_data,
    output logic signed [AUX_W-1:0]    tail_a,
    output logic signed [AUX_W-1:0]    tail_b
);

    localparam int CNT_W     = $clog2(FRAME_N);
    localparam int IDX_W     = $clog2(HALF_M);
    localparam int LAST_EMIT = 2 * PAIR_CNT - 1;

    fold_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic take;

    logic signed [SAMPLE_W-1:0] early_q [HALF_M];
    logic signed [FOLD_W-1:0]   fold_q  [2][HALF_M];
    logic signed [AUX_W-1:0]    aux_q   [2][HALF_M];
    logic signed [AUX_W-1:0]    tail_q  [2];

    logic [IDX_W-1:0]  mirror_idx, step_idx, prev_idx, lo_sel, hi_sel;
    logic              emit_lane;
    logic [SLOT_W-1:0] emit_slot;

    logic signed [FOLD_W-1:0] fold_sum, fold_dif;
    logic signed [AUX_W-1:0]  recur_next [2];
    logic signed [PAIR_W-1:0] pair_sum;

    // accept logic
    always_comb begin
        in_ready = (state_q == ST_IDLE) || (state_q == ST_LOAD_LO) || (state_q == ST_LOAD_HI);
        take     = in_valid && (((state_q == ST_IDLE) && in_start)
                             || (state_q == ST_LOAD_LO) || (state_q == ST_LOAD_HI));
    end

    // next state and step counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = ST_LOAD_LO;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_LOAD_LO: begin
                if (take) begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == CNT_W'(HALF_M - 1)) state_d = ST_LOAD_HI;
                end
            end
            ST_LOAD_HI: begin
                if (take) begin
                    if (cnt_q == CNT_W'(FRAME_N - 1)) begin
                        state_d = ST_RECUR;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_RECUR: begin
                if (cnt_q == CNT_W'(HALF_M - 1)) begin
                    state_d = ST_EMIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_EMIT: begin
                if (cnt_q == CNT_W'(LAST_EMIT)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // index decode
    always_comb begin
        mirror_idx = '0;
        if (cnt_q >= CNT_W'(HALF_M)) mirror_idx = IDX_W'(CNT_W'(FRAME_N - 1) - cnt_q);
        step_idx   = (cnt_q < CNT_W'(HALF_M)) ? IDX_W'(cnt_q) : '0;
        prev_idx   = (step_idx == '0) ? '0 : (step_idx - IDX_W'(1));
        emit_lane  = (cnt_q >= CNT_W'(PAIR_CNT));
        emit_slot  = emit_lane ? SLOT_W'(cnt_q - CNT_W'(PAIR_CNT)) : SLOT_W'(cnt_q);
        lo_sel     = IDX_W'(pair_low(int'(emit_slot)) - 1);
        hi_sel     = IDX_W'(HALF_M - pair_low(int'(emit_slot)) - 1);
    end

    mdst_fold_unit #(
        .IN_W   (SAMPLE_W),
        .FOLD_W (FOLD_W)
    ) u_fold (
        .early    (early_q[mirror_idx]),
        .late     (in_sample),
        .negate   (~mirror_idx[0]),
        .sum_fold (fold_sum),
        .dif_fold (fold_dif)
    );

    for (genvar l = 0; l < 2; l++) begin : g_lane
        mdst_recur_unit #(
            .FOLD_W (FOLD_W),
            .AUX_W  (AUX_W)
        ) u_recur (
            .first   (step_idx == '0),
            .flip    (~step_idx[0]),
            .fold_in (fold_q[l][step_idx]),
            .prev    (aux_q[l][prev_idx]),
            .next    (recur_next[l])
        );
    end

    mdst_pair_adder #(
        .AUX_W  (AUX_W),
        .PAIR_W (PAIR_W)
    ) u_pair (
        .op_lo    (aux_q[emit_lane][lo_sel]),
        .op_hi    (aux_q[emit_lane][hi_sel]),
        .pair_sum (pair_sum)
    );

    // storage: early half, folds, auxiliary sequences
    always_ff @(posedge clk) begin
        if (take && ((state_q == ST_IDLE) || (state_q == ST_LOAD_LO))) begin
            early_q[IDX_W'(cnt_q)] <= in_sample;
        end
        if (take && (state_q == ST_LOAD_HI)) begin
            fold_q[0][mirror_idx] <= fold_sum;
            fold_q[1][mirror_idx] <= fold_dif;
        end
        if (state_q == ST_RECUR) begin
            for (int l = 0; l < 2; l++) aux_q[l][step_idx] <= recur_next[l];
        end
    end

    // tails for the post-processor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q[0] <= '0;
            tail_q[1] <= '0;
        end else if ((state_q == ST_RECUR) && (cnt_q == CNT_W'(HALF_M - 1))) begin
            tail_q[0] <= recur_next[0];
            tail_q[1] <= recur_next[1];
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_valid <= 1'b0;
            pair_lane  <= 1'b0;
            pair_slot  <= '0;
            pair_data  <= '0;
        end else begin
            pair_valid <= (state_q == ST_EMIT);
            if (state_q == ST_EMIT) begin
                pair_lane <= emit_lane;
                pair_slot <= emit_slot;
                pair_data <= pair_sum;
            end
        end
    end

    assign tail_a = tail_q[0];
    assign tail_b = tail_q[1];

endmodule

// File: rtl/mdst_fold_pre_chk.sv
module mdst_fold_pre_chk
    import mdst_fold_pkg::*;
#(
    parameter int AUX_W = 21
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_ready,
    input logic                     pair_valid,
    input logic                     pair_lane,
    input logic [SLOT_W-1:0]        pair_slot,
    input logic signed [AUX_W-1:0]  tail_a,
    input logic signed [AUX_W-1:0]  tail_b
);

    assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (pair_slot < SLOT_W'(PAIR_CNT)));

    assert_slot_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && (pair_slot != SLOT_W'(PAIR_CNT - 1)))
        |=> (pair_valid && (pair_slot == SLOT_W'($past(pair_slot) + SLOT_W'(1)))
             && (pair_lane == $past(pair_lane))));

    assert_lane_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !pair_lane && (pair_slot == SLOT_W'(PAIR_CNT - 1)))
        |=> (pair_valid && pair_lane && (pair_slot == '0)));

    assert_first_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair_valid) |-> (!pair_lane && (pair_slot == '0)));

    assert_busy_at_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair_valid) |-> !in_ready);

    assert_tail_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && $past(pair_valid)) |-> ($stable(tail_a) && $stable(tail_b)));

endmodule

bind mdst_fold_pre mdst_fold_pre_chk #(.AUX_W(AUX_W)) u_fold_pre_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .pair_valid (pair_valid),
    .pair_lane  (pair_lane),
    .pair_slot  (pair_slot),
    .tail_a     (tail_a),
    .tail_b     (tail_b)
);

// File: tb/test_mdst_fold_pre.sv
`timescale 1ns/1ps
module test_mdst_fold_pre;
    import mdst_fold_pkg::*;

    localparam int SW = 16;
    localparam int AW = SW + 1 + $clog2(HALF_M);
    localparam int PW = AW + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_start = 1'b0;
    logic signed [SW-1:0] in_sample = '0;
    logic                 in_ready;
    logic                 pair_valid;
    logic                 pair_lane;
    logic [SLOT_W-1:0]    pair_slot;
    logic signed [PW-1:0] pair_data;
    logic signed [AW-1:0] tail_a;
    logic signed [AW-1:0] tail_b;

    int checks = 0;
    int fails = 0;
    int pairs_seen = 0;
    int pairs_expected = 0;
    bit finished = 1'b0;

    int     q_lane[$];
    int     q_slot[$];
    longint q_data[$];
    longint q_ta[$];
    longint q_tb[$];

    always #2 clk = ~clk;

    mdst_fold_pre #(.SAMPLE_W(SW)) i_mdst_fold_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_start   (in_start),
        .in_sample  (in_sample),
        .in_ready   (in_ready),
        .pair_valid (pair_valid),
        .pair_lane  (pair_lane),
        .pair_slot  (pair_slot),
        .pair_data  (pair_data),
        .tail_a     (tail_a),
        .tail_b     (tail_b)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model: pushes the expected items of one frame
    task automatic model_push(input longint s[FRAME_N]);
        longint u[HALF_M];
        longint v[HALF_M];
        longint a[HALF_M+1];
        longint b[HALF_M+1];
        int plo[PAIR_CNT] = '{1, 2, 4, 5, 3, 6};
        for (int i = 0; i < HALF_M; i++) begin
            u[i] = s[i] + s[FRAME_N-1-i];
            if (i % 2 == 0) u[i] = -u[i];
            v[i] = s[i] - s[FRAME_N-1-i];
        end
        a[1] = u[0];
        b[1] = v[0];
        for (int i = 1; i < HALF_M; i++) begin
            a[i+1] = ((i % 2 == 1) ? u[i] : -u[i]) - a[i];
            b[i+1] = ((i % 2 == 1) ? v[i] : -v[i]) - b[i];
        end
        for (int k = 0; k < PAIR_CNT; k++) begin
            q_lane.push_back(0);
            q_slot.push_back(k);
            q_data.push_back(a[plo[k]] + a[HALF_M-plo[k]]);
        end
        for (int k = 0; k < PAIR_CNT; k++) begin
            q_lane.push_back(1);
            q_slot.push_back(k);
            q_data.push_back(b[plo[k]] + b[HALF_M-plo[k]]);
        end
        q_ta.push_back(a[HALF_M]);
        q_tb.push_back(b[HALF_M]);
        pairs_expected += 2 * PAIR_CNT;
    endtask

    // driver: one frame, optional gaps, optional pokes while busy
    task automatic send_frame(input longint s[FRAME_N], input int gap, input bit poke);
        model_push(s);
        while (!in_ready) @(negedge clk);
        for (int i = 0; i < FRAME_N; i++) begin
            if (gap > 0 && (i % 4) == 2) begin
                in_valid = 1'b0;
                in_start = 1'b0;
                repeat (gap) @(negedge clk);
            end
            in_valid  = 1'b1;
            in_start  = (i == 0);
            in_sample = s[i][SW-1:0];
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_start = 1'b0;
        check(in_ready == 1'b0, "R3", "in_ready after last sample", in_ready, 0);
        if (poke) begin
            repeat (3) begin
                in_valid  = 1'b1;
                in_start  = 1'b1;
                in_sample = 16'sd4321;
                @(negedge clk);
            end
            in_valid = 1'b0;
            in_start = 1'b0;
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && pair_valid && !finished) begin
            int el;
            int sl;
            longint ed;
            pairs_seen++;
            if (q_data.size() == 0) begin
                check(1'b0, "R8", "unexpected pair beat", pair_slot, -1);
            end else begin
                el = q_lane.pop_front();
                sl = q_slot.pop_front();
                ed = q_data.pop_front();
                check(int'(pair_lane) == el, "R8", "pair_lane", pair_lane, el);
                check(int'(pair_slot) == sl, "R8", "pair_slot", pair_slot, sl);
                if (el == 0)
                    check(longint'(pair_data) == ed, "R4 R6 R7", "lane a operand", pair_data, ed);
                else
                    check(longint'(pair_data) == ed, "R5 R6 R7", "lane b operand", pair_data, ed);
                if (el == 0 && sl == 0) begin
                    longint ta;
                    longint tb;
                    ta = q_ta.pop_front();
                    tb = q_tb.pop_front();
                    check(longint'(tail_a) == ta, "R9", "tail_a", tail_a, ta);
                    check(longint'(tail_b) == tb, "R9", "tail_b", tail_b, tb);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        longint f[FRAME_N];
        int unsigned seed;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        check(pair_valid == 1'b0, "R1", "pair_valid in reset", pair_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(pair_valid == 1'b0, "R1", "pair_valid after reset", pair_valid, 0);

        // R2: valid without start in idle is ignored
        in_valid  = 1'b1;
        in_sample = 16'sd7777;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(pair_valid == 1'b0, "R2", "no output from stray valid", pair_valid, 0);
        check(in_ready == 1'b1, "R2", "still idle after stray valid", in_ready, 1);

        // zeros
        for (int i = 0; i < FRAME_N; i++) f[i] = 0;
        send_frame(f, 0, 1'b0);
        // ramp
        for (int i = 0; i < FRAME_N; i++) f[i] = longint'(i * 100 - 1300);
        send_frame(f, 0, 1'b0);
        // ramp with gaps on valid (R2) and busy pokes (R3)
        for (int i = 0; i < FRAME_N; i++) f[i] = longint'(i * 37 - 400);
        send_frame(f, 2, 1'b1);
        // R10: full scale positive and negative
        for (int i = 0; i < FRAME_N; i++) f[i] = 32767;
        send_frame(f, 0, 1'b0);
        for (int i = 0; i < FRAME_N; i++) f[i] = -32768;
        send_frame(f, 0, 1'b1);
        // R10: mirrored alternating extremes drive the recurrence to its peak
        for (int i = 0; i < HALF_M; i++) begin
            f[i] = (i % 2 == 1) ? -32768 : 32767;
            f[FRAME_N-1-i] = f[i];
        end
        send_frame(f, 0, 1'b0);
        for (int i = 0; i < HALF_M; i++) begin
            f[i] = (i % 2 == 0) ? -32768 : 32767;
            f[FRAME_N-1-i] = -f[i] - 1;
        end
        send_frame(f, 1, 1'b0);
        // pseudo-random frames
        seed = 32'hACE1;
        for (int n = 0; n < 4; n++) begin
            for (int i = 0; i < FRAME_N; i++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                f[i] = longint'($signed(seed[31:16]));
            end
            send_frame(f, n, n[0]);
        end

        repeat (40) @(negedge clk);
        check(pairs_seen == pairs_expected, "R8", "total pair beats", pairs_seen, pairs_expected);
        check(q_data.size() == 0, "R8", "leftover expected beats", q_data.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule